// File: doc/BRIEF.md
# Three-Channel Code-Spread Symbol Transmitter

This block is the sending side of a code-division test link. It holds three independent bit streams, one per channel. Each bit is spread over a 127-chip pseudo-noise sequence that belongs to that channel. At every clock it adds the three spread chips into one 2-bit symbol. A one-cycle frame marker shows the despreader where the first chip of each 127-chip frame sits. The transmitter and the receiver share one clock, so no timing recovery is needed.

Each channel's code comes from a 7-bit Fibonacci shift register with its own feedback taps, and every register starts at all-ones. The data sources repeat fixed 8-bit patterns. A channel moves to its next pattern bit only at a frame boundary, so one data bit covers exactly one full code period.

A two-state controller sequences the block. State `ST_HOLD` is entered on reset and keeps the outputs at zero. The transition HOLD→SEND is taken on the first clock edge with reset low. State `ST_SEND` emits one symbol per clock. The transition SEND→HOLD happens only through reset.

Top module: `cdma_spread_tx`

## Requirements
- R1: In `ST_SEND`, `tx_sym` equals the number of channels whose data bit XOR current chip is 1, a value from 0 to 3.
- R2: Each code register is 7 bits, reset to all-ones, chip = bit 6. Each step shifts left with new bit 0 = bit 6 XOR bit k, where k = 5 for channel 1 (x^7+x^6+1), k = 2 for channel 2 (x^7+x^3+1) and k = 0 for channel 3 (x^7+x+1).
- R3: Every code sequence repeats with a period of exactly 127 chips, and one data bit lasts exactly 127 cycles.
- R4: The data patterns are 01010101 (channel 1), 00110011 (channel 2) and 00001111 (channel 3), read left to right. Frame n after reset uses bit n mod 8.
- R5: `frame_start` is a one-cycle pulse that is high exactly on chip 0 of each frame, where all code registers are all-ones. It occurs once every 127 cycles.
- R6: While reset is high, and in the first cycle after it is released, `tx_sym` = 0 and `frame_start` = 0. Chip 0 of frame 0 appears after the second rising edge with reset low.
- R7: Reset asserted in the middle of a frame restarts the block at frame 0, chip 0, with pattern bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_sym | output | 2 | Sum of the three spread chips |
| frame_start | output | 1 | High on the first chip of each frame |

## Verification
The scoreboard replays the full symbol stream over nine frames, which crosses the 8-frame wrap of the patterns. A design with a wrong tap or wrong shift direction breaks the stream within a few chips. A design whose period is off by one makes `frame_start` drift against the expected 127-cycle spacing. A pattern source that advances one chip too early or too late corrupts the last or the first chip of each frame. A reset applied mid-frame exposes a design that keeps its pattern index or its code state, and the hold cycle after release catches a design that starts emitting one cycle early.

// File: rtl/cdma_tx_pkg.sv
package cdma_tx_pkg;
    localparam int NCH     = 3;
    localparam int PN_W    = 7;
    localparam int PAT_LEN = 8;
    localparam int SYM_W   = $clog2(NCH + 1);
    localparam int IDX_W   = $clog2(PAT_LEN);

    // feedback masks, index 0 = channel 1
    localparam logic [NCH-1:0][PN_W-1:0] PN_TAPS = {
        7'b1000001,  // channel 3
        7'b1000100,  // channel 2
        7'b1100000   // channel 1
    };

    // data patterns, read MSB first
    localparam logic [NCH-1:0][PAT_LEN-1:0] PATTERNS = {
        8'b00001111,
        8'b00110011,
        8'b01010101
    };

    typedef enum logic {ST_HOLD, ST_SEND} tx_state_e;

    function automatic logic [SYM_W-1:0] ones_count(input logic [NCH-1:0] v);
        logic [SYM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NCH; i++) acc = acc + SYM_W'(v[i]);
        return acc;
    endfunction
endpackage

// File: rtl/cdma_frame_ctl.sv
module cdma_frame_ctl
    import cdma_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic run
);
    tx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_SEND;
            ST_SEND: state_d = ST_SEND;
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SEND: run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    // R6: the hold state lasts a single cycle once reset is low
    a_r6_hold_leaves: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |=> (state_q == ST_SEND));
endmodule

// File: rtl/cdma_pn_gen.sv
module cdma_pn_gen #(
    parameter int            W    = 7,
    parameter logic [W-1:0]  TAPS = 7'b1100000
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic chip,
    output logic at_start,
    output logic frame_last
);
    logic [W-1:0] lfsr_q, lfsr_d;

    assign lfsr_d     = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
    assign chip       = lfsr_q[W-1];
    assign at_start   = &lfsr_q;
    assign frame_last = &lfsr_d;

    always_ff @(posedge clk) begin
        if (rst)      lfsr_q <= '1;
        else if (adv) lfsr_q <= lfsr_d;
    end

    // R2: register never locks up in the all-zero state
    a_r2_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
    // R2: first cycle after reset starts from all-ones
    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lfsr_q == '1));
    // R3: the all-ones state is never held for two consecutive steps
    a_r3_no_stall: assert property (@(posedge clk) disable iff (rst)
        (at_start && adv) |=> !at_start);
endmodule

// File: rtl/cdma_pattern_src.sv
module cdma_pattern_src #(
    parameter int                LEN = 8,
    parameter logic [LEN-1:0]    PAT = 8'b01010101,
    localparam int               IW  = $clog2(LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic data_bit
);
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else if (adv) begin
            if (idx_q == IW'(LEN - 1)) idx_q <= '0;
            else                       idx_q <= idx_q + 1'b1;
        end
    end

    assign data_bit = PAT[IW'(LEN - 1) - idx_q];

    // R4: the pattern bit only moves at a frame boundary
    a_r4_idx_steady: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(idx_q));
endmodule

// File: rtl/cdma_spread_tx.sv
module cdma_spread_tx
    import cdma_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [SYM_W-1:0] tx_sym,
    output logic             frame_start
);
    logic           run;
    logic [NCH-1:0] chip_v, start_v, last_v, data_v, spread_v;
    logic           frame_end;

    cdma_frame_ctl u_ctl (.clk(clk), .rst(rst), .run(run));

    assign frame_end = run & (&last_v);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cdma_pn_gen #(.W(PN_W), .TAPS(PN_TAPS[g])) u_pn (
            .clk(clk), .rst(rst), .adv(run),
            .chip(chip_v[g]), .at_start(start_v[g]), .frame_last(last_v[g]));
        cdma_pattern_src #(.LEN(PAT_LEN), .PAT(PATTERNS[g])) u_pat (
            .clk(clk), .rst(rst), .adv(frame_end), .data_bit(data_v[g]));
        assign spread_v[g] = chip_v[g] ^ data_v[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sym      <= '0;
            frame_start <= 1'b0;
        end else if (run) begin
            tx_sym      <= ones_count(spread_v);
            frame_start <= &start_v;
        end else begin
            tx_sym      <= '0;
            frame_start <= 1'b0;
        end
    end

    // R1: emitted symbol is the count of spread ones of the previous chip
    a_r1_sum: assert property (@(posedge clk) disable iff (rst)
        $past(run) |-> (tx_sym == ones_count($past(spread_v))));
    // R5: frame marker never lasts two cycles
    a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);
    // R3: all code registers reach their frame start together
    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        (start_v == '0) || (start_v == '1));
endmodule

// File: tb/tb_cdma_spread_tx.sv
module tb_cdma_spread_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tx_sym;
    logic       frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    int last_sync = -1;
    int cyc = 0;

    typedef struct { logic [1:0] sym; logic sync; } exp_t;
    exp_t q[$];

    cdma_spread_tx dut (.clk(clk), .rst(rst), .tx_sym(tx_sym), .frame_start(frame_start));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [6:0] model_step(input logic [6:0] s, input int k);
        return {s[5:0], s[6] ^ s[k]};
    endfunction

    // driver: expected symbols for nf frames starting from reset state
    task automatic push_frames(input int nf);
        logic [6:0] s1, s2, s3;
        logic [7:0] p1, p2, p3;
        s1 = '1; s2 = '1; s3 = '1;
        p1 = 8'b01010101; p2 = 8'b00110011; p3 = 8'b00001111;
        for (int f = 0; f < nf; f++) begin
            for (int c = 0; c < 127; c++) begin
                exp_t e;
                e.sym  = 2'((s1[6] ^ p1[7 - (f % 8)])) + 2'((s2[6] ^ p2[7 - (f % 8)]))
                       + 2'((s3[6] ^ p3[7 - (f % 8)]));
                e.sync = (c == 0);
                q.push_back(e);
                s1 = model_step(s1, 5);
                s2 = model_step(s2, 2);
                s3 = model_step(s3, 0);
            end
        end
    endtask

    // monitor: compare two time units after each edge
    always @(posedge clk) begin
        #2;
        if (mon_en && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(tx_sym == e.sym, "R1 symbol", tx_sym, e.sym);
            check(frame_start == e.sync, "R5 frame marker", frame_start, e.sync);
            if (frame_start) begin
                if (last_sync >= 0)
                    check(cyc - last_sync == 127, "R3 frame period", cyc - last_sync, 127);
                last_sync = cyc;
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic startup(input string tag);
        repeat (2) @(negedge clk);
        check(tx_sym == 0 && frame_start == 0, {tag, " in reset"}, {tx_sym, frame_start}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_sym == 0 && frame_start == 0, {tag, " hold cycle"}, {tx_sym, frame_start}, 0);
        last_sync = -1;
        push_frames(tag == "R6" ? 9 : 2);
        mon_en = 1'b1;
    endtask

    initial begin
        // R6, R2, R4: reset state, hold cycle, then nine frames across the pattern wrap
        startup("R6");
        wait (q.size() == 0);
        @(negedge clk);
        // R7: reset in the middle of a frame restarts from frame 0
        repeat (40) @(negedge clk);
        mon_en = 1'b0;
        rst = 1'b1;
        startup("R7");
        wait (q.size() == 0);
        @(negedge clk);
        finish_run();
    end
endmodule